// File: doc/BRIEF.md
# Two-Minimum Residue Aggregator

This block compresses a run of redundancy-free trellis inputs into seven aggregated soft bits, one for each residue class of the input position modulo 7. Each cycle it may accept one bit LLR, given as a sign bit and a 7-bit magnitude. For every residue class it keeps the product of the input signs as a running parity. Over the whole run it keeps only the two smallest magnitudes seen, with the residue class each came from.

When the input marked last has been taken, the block publishes seven aggregated values. The residue holding the smallest magnitude receives that magnitude. The residue holding the second smallest receives the second magnitude, unless it is the same residue. Every other residue is saturated: it keeps its sign and has its infinity flag set. A forward recursion downstream can stay frozen while the run streams in, and then consume the seven values.

The control is a three-state machine. ST_IDLE waits for the first input of a run, and the accumulators behave as freshly reset. ST_RUN accumulates further inputs. ST_DONE is the single cycle in which the result is flagged. The transitions are: idle_to_run (valid input, not last), idle_to_done (valid input that is also last), run_to_done (valid input that is last), done_to_idle (always after one cycle). ST_RUN holds while no last input arrives.

Top module: `twomin_aggregator`

## Requirements
- R1: Input number k of a run, counting accepted inputs from 0, belongs to residue k mod 7. Cycles with in_valid low do not advance k. A new run restarts k at 0.
- R2: The output sign of residue r is the XOR of in_sign (1 = negative) over all inputs of the run in residue r. It is 0 (positive) when there are none.
- R3: The minima are updated only on a strictly smaller magnitude. Among equal magnitudes the earlier input keeps the lower rank, so the two kept values are the first two entries of the run sorted stably by magnitude.
- R4: A finite residue has out_inf low and carries its magnitude in out_mag bits [7r+6:7r]. A saturated residue has out_inf high and magnitude 0. After every run, one or two residues are finite.
- R5: When both minima come from the same residue, that residue carries the smaller magnitude and every other residue is saturated.
- R6: A run of a single input leaves the second minimum at infinity with residue 1, so only residue 0 is finite.
- R7: out_done is high for exactly one cycle, the cycle after the edge that took the last input. The outputs are held from then until the next run completes.
- R8: Inputs presented during the out_done cycle are ignored. The next run starts with the first valid input after it.
- R9: After reset, out_done is low, every out_inf bit is high, and all signs and magnitudes are 0.
- R10: A run may contain idle cycles of any length without changing its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An input LLR is present |
| in_last | input | 1 | This input closes the run |
| in_sign | input | 1 | LLR sign, 1 = negative |
| in_mag | input | 7 | LLR magnitude |
| out_done | output | 1 | One-cycle flag: result published |
| out_sign | output | 7 | Aggregated sign per residue |
| out_inf | output | 7 | Saturation flag per residue |
| out_mag | output | 49 | Magnitude per residue, residue r at bits 7r+6:7r |

## Verification
The main function is tried with a sixteen-value run of mixed signs broken by an idle gap. This separates a correct residue count from one that also advances on idle cycles. Runs of equal magnitudes tell strict from non-strict comparison. A run whose two smallest values fall seven positions apart tells apart the same-residue case. A single-input run exposes the handling of an untouched second minimum. A last input offered during the done cycle and a 100-input pseudo-random run show whether stray inputs leak into the next result and whether the sign parity and ranking hold over many wraps of the residue.

// File: rtl/agg_pkg.sv
package agg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DONE
    } agg_state_t;
endpackage

// File: rtl/agg_residue_ctr.sv
module agg_residue_ctr #(
    parameter int NUM_RES = 7,
    parameter int RES_W   = $clog2(NUM_RES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fresh,
    input  logic             step,
    output logic [RES_W-1:0] res
);
    logic [RES_W-1:0] cnt_q;

    assign res = fresh ? '0 : cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (step)
            cnt_q <= (res == RES_W'(NUM_RES - 1)) ? '0 : res + 1'b1;
    end

    // R1: the stored position class never leaves 0..NUM_RES-1
    assert_res_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < NUM_RES);
endmodule

// File: rtl/agg_sign_acc.sv
module agg_sign_acc #(
    parameter int NUM_RES = 7,
    parameter int RES_W   = $clog2(NUM_RES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fresh,
    input  logic               step,
    input  logic [RES_W-1:0]   res,
    input  logic               in_sign,
    output logic [NUM_RES-1:0] sign_nx
);
    logic [NUM_RES-1:0] sign_q;

    for (genvar g = 0; g < NUM_RES; g++) begin : g_sign
        assign sign_nx[g] = (fresh ? 1'b0 : sign_q[g])
                          ^ (step && (res == RES_W'(g)) && in_sign);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sign_q <= '0;
        else if (step)
            sign_q <= sign_nx;
    end

    // R2: a mid-run input may flip at most the sign of its own class
    assert_one_sign_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !fresh) |=> ($countones(sign_q ^ $past(sign_q)) <= 1));
endmodule

// File: rtl/agg_min_track.sv
module agg_min_track #(
    parameter int MAG_W = 7,
    parameter int RES_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fresh,
    input  logic             step,
    input  logic [RES_W-1:0] res,
    input  logic [MAG_W-1:0] in_mag,
    output logic [MAG_W:0]   min1_nx,
    output logic [RES_W-1:0] ind1_nx,
    output logic [MAG_W:0]   min2_nx,
    output logic [RES_W-1:0] ind2_nx
);
    localparam int KEY_W = MAG_W + 1;
    localparam logic [KEY_W-1:0] INF_KEY = {1'b1, {MAG_W{1'b0}}};

    logic [KEY_W-1:0] min1_q, min2_q, b_min1, b_min2, key;
    logic [RES_W-1:0] ind1_q, ind2_q, b_ind1, b_ind2;

    assign key    = {1'b0, in_mag};
    assign b_min1 = fresh ? INF_KEY : min1_q;
    assign b_min2 = fresh ? INF_KEY : min2_q;
    assign b_ind1 = fresh ? '0 : ind1_q;
    assign b_ind2 = fresh ? RES_W'(1) : ind2_q;

    always_comb begin
        min1_nx = b_min1;
        ind1_nx = b_ind1;
        min2_nx = b_min2;
        ind2_nx = b_ind2;
        if (step) begin
            if (key < b_min1) begin
                min2_nx = b_min1;
                ind2_nx = b_ind1;
                min1_nx = key;
                ind1_nx = res;
            end else if (key < b_min2) begin
                min2_nx = key;
                ind2_nx = res;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            min1_q <= INF_KEY;
            min2_q <= INF_KEY;
            ind1_q <= '0;
            ind2_q <= RES_W'(1);
        end else if (step) begin
            min1_q <= min1_nx;
            min2_q <= min2_nx;
            ind1_q <= ind1_nx;
            ind2_q <= ind2_nx;
        end
    end

    // R3: the rank order of the two kept magnitudes never inverts
    assert_min_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        min1_q <= min2_q);
    // R3: after any accepted input the smallest kept value is finite
    assert_min1_finite_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !min1_q[MAG_W]);
endmodule

// File: rtl/twomin_aggregator.sv
module twomin_aggregator #(
    parameter int NUM_RES = 7,
    parameter int MAG_W   = 7,
    parameter int RES_W   = $clog2(NUM_RES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_last,
    input  logic                     in_sign,
    input  logic [MAG_W-1:0]         in_mag,
    output logic                     out_done,
    output logic [NUM_RES-1:0]       out_sign,
    output logic [NUM_RES-1:0]       out_inf,
    output logic [NUM_RES*MAG_W-1:0] out_mag
);
    import agg_pkg::*;

    agg_state_t state_q, state_nx;
    logic fresh, step, close;
    logic [RES_W-1:0]   res;
    logic [NUM_RES-1:0] sign_nx;
    logic [MAG_W:0]     min1_nx, min2_nx;
    logic [RES_W-1:0]   ind1_nx, ind2_nx;
    logic [NUM_RES-1:0]       agg_inf;
    logic [NUM_RES*MAG_W-1:0] agg_mag;

    assign fresh = (state_q != ST_RUN);
    assign step  = in_valid && (state_q != ST_DONE);
    assign close = step && in_last;

    agg_residue_ctr #(.NUM_RES(NUM_RES), .RES_W(RES_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .fresh(fresh), .step(step), .res(res)
    );

    agg_sign_acc #(.NUM_RES(NUM_RES), .RES_W(RES_W)) u_sign (
        .clk(clk), .rst_n(rst_n), .fresh(fresh), .step(step), .res(res),
        .in_sign(in_sign), .sign_nx(sign_nx)
    );

    agg_min_track #(.MAG_W(MAG_W), .RES_W(RES_W)) u_min (
        .clk(clk), .rst_n(rst_n), .fresh(fresh), .step(step), .res(res),
        .in_mag(in_mag), .min1_nx(min1_nx), .ind1_nx(ind1_nx),
        .min2_nx(min2_nx), .ind2_nx(ind2_nx)
    );

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (step) state_nx = in_last ? ST_DONE : ST_RUN;
            ST_RUN:  if (close) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        agg_inf = '1;
        agg_mag = '0;
        for (int r = 0; r < NUM_RES; r++) begin
            if (ind1_nx == RES_W'(r)) begin
                agg_inf[r] = min1_nx[MAG_W];
                agg_mag[r*MAG_W +: MAG_W] = min1_nx[MAG_W-1:0];
            end else if (ind2_nx == RES_W'(r)) begin
                agg_inf[r] = min2_nx[MAG_W];
                agg_mag[r*MAG_W +: MAG_W] = min2_nx[MAG_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_done <= 1'b0;
            out_sign <= '0;
            out_inf  <= '1;
            out_mag  <= '0;
        end else begin
            out_done <= close;
            if (close) begin
                out_sign <= sign_nx;
                out_inf  <= agg_inf;
                out_mag  <= agg_mag;
            end
        end
    end

    // R7: the result flag follows the closing input by one edge
    assert_done_follows_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        close |=> out_done);
    // R7: the result flag is a single-cycle pulse
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> !out_done);
    // R4: one or two residues stay finite in a published result
    assert_finite_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> ($countones(~out_inf) >= 1 && $countones(~out_inf) <= 2));
    // R8: whatever arrives in the done cycle leaves the published values alone
    assert_ignore_in_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> ($stable(out_mag) && $stable(out_inf) && $stable(out_sign)));
endmodule

// File: tb/twomin_aggregator_test.sv
module twomin_aggregator_test;
    localparam int NR = 7;
    localparam int MW = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0, in_sign = 1'b0;
    logic [MW-1:0] in_mag = '0;
    logic out_done;
    logic [NR-1:0] out_sign, out_inf;
    logic [NR*MW-1:0] out_mag;

    twomin_aggregator uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .in_sign(in_sign), .in_mag(in_mag), .out_done(out_done),
        .out_sign(out_sign), .out_inf(out_inf), .out_mag(out_mag)
    );

    always #10 clk = ~clk;

    int total = 0, bad = 0;
    bit finished = 0;
    string tag = "R9";
    int run_mag[$];
    int run_sgn[$];
    bit exp_done = 0;
    int exp_sign[NR], exp_inf[NR], exp_mag[NR];
    int lfsr = 32'h1d2b;

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run hung (actual running, expected finished)");
        summary();
    end

    task automatic compute_expected();
        int i1, i2, r1, r2;
        i1 = -1; i2 = -1;
        for (int k = 0; k < run_mag.size(); k++)
            if (i1 < 0 || run_mag[k] < run_mag[i1]) i1 = k;
        for (int k = 0; k < run_mag.size(); k++)
            if (k != i1 && (i2 < 0 || run_mag[k] < run_mag[i2])) i2 = k;
        r1 = i1 % NR;
        r2 = (i2 < 0) ? 1 : i2 % NR;
        for (int r = 0; r < NR; r++) begin
            exp_sign[r] = 0;
            for (int k = r; k < run_mag.size(); k += NR) exp_sign[r] ^= run_sgn[k];
            exp_inf[r] = 1;
            exp_mag[r] = 0;
            if (r == r1) begin
                exp_inf[r] = 0; exp_mag[r] = run_mag[i1];
            end else if (r == r2 && i2 >= 0) begin
                exp_inf[r] = 0; exp_mag[r] = run_mag[i2];
            end
        end
    endtask

    task automatic compare();
        bit ok;
        ok = 1;
        total++;
        if (out_done !== exp_done) begin
            ok = 0;
            $display("FAIL %s done: actual %0b expected %0b", tag, out_done, exp_done);
        end
        for (int r = 0; r < NR; r++) begin
            if (out_sign[r] !== exp_sign[r][0] || out_inf[r] !== exp_inf[r][0]
                || int'(out_mag[r*MW +: MW]) != exp_mag[r]) begin
                ok = 0;
                $display("FAIL %s residue %0d: actual s=%0b i=%0b m=%0d expected s=%0d i=%0d m=%0d",
                         tag, r, out_sign[r], out_inf[r], out_mag[r*MW +: MW],
                         exp_sign[r], exp_inf[r], exp_mag[r]);
            end
        end
        if (!ok) bad++;
    endtask

    task automatic drive(input bit v, input bit l, input bit s, input int m);
        in_valid = v; in_last = l; in_sign = s; in_mag = MW'(m);
        @(posedge clk);
        #1;
        if (exp_done) begin
            exp_done = 0;
        end else begin
            exp_done = 0;
            if (v) begin
                run_mag.push_back(m);
                run_sgn.push_back(int'(s));
                if (l) begin
                    compute_expected();
                    exp_done = 1;
                    run_mag.delete();
                    run_sgn.delete();
                end
            end
        end
        @(negedge clk);
        compare();
    endtask

    task automatic llr(input int v, input bit l);
        drive(1, l, v < 0, v < 0 ? -v : v);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0);
    endtask

    initial begin
        for (int r = 0; r < NR; r++) begin
            exp_sign[r] = 0; exp_inf[r] = 1; exp_mag[r] = 0;
        end
        // R9: reset state
        repeat (3) @(negedge clk);
        tag = "R9";
        compare();
        rst_n = 1'b1;
        idle(2);

        // R1 R2 R4 R10: mixed signs with an idle gap inside the run
        begin
            int seq[16] = '{-14, 31, 24, 12, 31, 20, 6, -31, 19, 15, -19, -8, 15, 12, 5, -11};
            tag = "R1 R2 R4 R10";
            for (int k = 0; k < 16; k++) begin
                llr(seq[k], k == 15);
                if (k == 4) idle(3);
            end
            tag = "R7";
            idle(4);
        end

        // R3: equal magnitudes keep earlier ranking
        tag = "R3";
        llr(9, 0); llr(-9, 0); llr(9, 0); llr(20, 0); llr(-9, 1);
        idle(1);

        // R5: both minima in residue 0
        tag = "R5";
        llr(50, 0);
        for (int k = 1; k < 7; k++) llr(-60, 0);
        llr(-5, 1);
        idle(1);

        // R6: single-input runs, including magnitude zero
        tag = "R6";
        llr(-33, 1);
        idle(1);
        drive(1, 1, 0, 0);
        idle(1);

        // R8: a last input offered in the done cycle is ignored
        tag = "R8";
        llr(40, 0); llr(-41, 1);
        drive(1, 1, 1, 0);
        llr(70, 0); llr(-3, 0); llr(64, 1);
        llr(2, 0); llr(-2, 1);
        idle(2);

        // R1 R2 R3 R4: pseudo-random run of 100
        tag = "R1 R2 R3 R4";
        for (int k = 0; k < 100; k++) begin
            lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
            drive(1, k == 99, lfsr[20], 1 + ((lfsr >>> 8) % 127));
        end
        idle(3);
        summary();
    end
endmodule